// File: doc/BRIEF.md
# Two-Level ATM Channel Lookup Engine

This block turns an arriving cell header into an internal channel code. A header is made of a 5-bit PHY address, a 12-bit VPI and a 16-bit VCI. The block resolves it with two dependent reads from a 32-bit, word-addressed table memory. A configured VPI mask picks out some of the VPI bits. Those bits are packed into a dense index that selects a word in a first-level (path) table. That word gives a VCI mask and an offset into the second-level (channel) tables. The VCI bits picked out by that mask are packed in the same way and added to the channel-table base and the offset. The word found there carries the channel code and a miss flag.

Bit packing scans the mask from bit 0 upward. Each set mask bit copies the key bit at that position into the next free index bit, starting at index bit 0. When multi-PHY operation is enabled, bit 4 of the PHY address chooses between two complete sets of table bases. Bits 3..0 of the PHY address travel with the result. In single-PHY operation, the PHY address is treated as zero.

Top module: `atm_chan_lookup`

## Requirements
- R1: After reset, `hdr_ready` is 1, while `res_valid`, `mem_rd`, `res_code`, `res_nomatch` and `res_phy` are all 0.
- R2: The first read is issued in the cycle after a header is accepted. Its address is the selected path base plus the VPI bits chosen by `cfg_vp_mask`, packed upward from bit 0 in mask order.
- R3: A path-table word is split into two fields. Bits 31..16 are the VCI mask and bits 15..0 are the channel-table offset.
- R4: The second read comes two cycles after the first. Its address is the selected channel base, plus the offset, plus the VCI bits chosen by the VCI mask, packed upward from bit 0. All additions wrap modulo 2^ADDR_W.
- R5: `res_code` equals bits 31..16 of the channel-table word and `res_nomatch` equals its bit 0 (0 = hit, 1 = miss). Bits 15..1 of that word have no effect on any output.
- R6: When `cfg_multi_phy` is 1 and `hdr_phy[4]` is 1, both reads use `cfg_vp_base1`/`cfg_vc_base1`. When `cfg_multi_phy` is 1 and `hdr_phy[4]` is 0, both reads use `cfg_vp_base0`/`cfg_vc_base0`. In multi-PHY mode, `res_phy` equals `hdr_phy[3:0]`.
- R7: When `cfg_multi_phy` is 0, set 0 is always used whatever `hdr_phy[4]` is, and `res_phy` is 0.
- R8: `res_valid` is high for exactly one cycle, the fifth cycle after the accepting clock edge. After that cycle `hdr_ready` returns to 1.
- R9: `hdr_ready` is 1 only while no lookup is in progress. A header offered while `hdr_ready` is 0 is ignored and does not alter the addresses or the result of the lookup in progress.
- R10: A zero VCI mask gives a zero channel index, so the second read goes to the channel base plus the offset.
- R11: `res_code`, `res_nomatch` and `res_phy` stay unchanged outside the cycle in which `res_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_multi_phy | input | 1 | 1 = multi-PHY operation (PHY bit 4 selects the table set) |
| cfg_vp_mask | input | 12 | Selects the VPI bits that form the path-table index |
| cfg_vp_base0 | input | ADDR_W | Path-table base, set 0 |
| cfg_vc_base0 | input | ADDR_W | Channel-table base, set 0 |
| cfg_vp_base1 | input | ADDR_W | Path-table base, set 1 |
| cfg_vc_base1 | input | ADDR_W | Channel-table base, set 1 |
| hdr_valid | input | 1 | Header offered |
| hdr_ready | output | 1 | Block idle, header accepted when `hdr_valid` is high |
| hdr_phy | input | 5 | PHY address of the cell |
| hdr_vpi | input | 12 | VPI of the cell |
| hdr_vci | input | 16 | VCI of the cell |
| mem_rd | output | 1 | Table read strobe |
| mem_addr | output | ADDR_W | Table word address |
| mem_rdata | input | 32 | Read data, valid one cycle after `mem_rd` |
| res_valid | output | 1 | One-cycle result strobe |
| res_code | output | 16 | Channel code |
| res_nomatch | output | 1 | Miss flag (1 = no match) |
| res_phy | output | 4 | Low PHY address bits (0 in single-PHY mode) |

## Verification
The hardest case to reach from the ports is a second header that arrives while a lookup is in flight. Catching it as ignored needs a header that would lead to different addresses than the one being served. The bench therefore holds `hdr_valid` high with an unrelated header during the path-table wait cycle. It then checks that the second read address and the final code still belong to the first header. The table memory is filled with words whose reserved bits are non-zero. One path word is overwritten to carry a zero VCI mask, which reaches the base-plus-offset case directly.

// File: rtl/chlk_pkg.sv
package chlk_pkg;

    localparam int PHY_W  = 5;
    localparam int VPI_W  = 12;
    localparam int VCI_W  = 16;
    localparam int WORD_W = 32;
    localparam int CODE_W = 16;
    localparam int HALF_W = WORD_W / 2;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RD_VP = 3'd1,
        ST_WT_VP = 3'd2,
        ST_RD_VC = 3'd3,
        ST_WT_VC = 3'd4,
        ST_DONE  = 3'd5
    } chlk_state_e;

    typedef struct packed {
        logic [PHY_W-1:0] phy;
        logic [VPI_W-1:0] vpi;
        logic [VCI_W-1:0] vci;
    } chlk_hdr_t;

    typedef struct packed {
        logic [HALF_W-1:0] vci_mask;
        logic [HALF_W-1:0] vc_off;
    } chlk_path_ent_t;

    typedef struct packed {
        logic [CODE_W-1:0]        code;
        logic [WORD_W-CODE_W-2:0] rsvd;
        logic                     nomatch;
    } chlk_chan_ent_t;

    function automatic logic pick_set1(input logic multi, input logic [PHY_W-1:0] phy);
        return multi & phy[PHY_W-1];
    endfunction

    function automatic logic [PHY_W-2:0] phy_low(input logic multi, input logic [PHY_W-1:0] phy);
        return multi ? phy[PHY_W-2:0] : '0;
    endfunction

endpackage

// File: rtl/chlk_compact.sv
module chlk_compact #(
    parameter int W = 16
) (
    input  logic [W-1:0] key,
    input  logic [W-1:0] mask,
    output logic [W-1:0] packed_idx
);
    always_comb begin
        int pos;
        packed_idx = '0;
        pos = 0;
        for (int i = 0; i < W; i++) begin
            if (mask[i]) begin
                packed_idx[pos] = key[i];
                pos = pos + 1;
            end
        end
    end
endmodule

// File: rtl/chlk_addr.sv
module chlk_addr
    import chlk_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                 set1,
    input  logic [ADDR_W-1:0]    vp_base0,
    input  logic [ADDR_W-1:0]    vc_base0,
    input  logic [ADDR_W-1:0]    vp_base1,
    input  logic [ADDR_W-1:0]    vc_base1,
    input  logic [VPI_W-1:0]     vp_mask,
    input  logic [VPI_W-1:0]     vpi,
    input  logic [VCI_W-1:0]     vci,
    input  chlk_path_ent_t       path_ent,
    output logic [ADDR_W-1:0]    vp_addr,
    output logic [ADDR_W-1:0]    vc_addr
);
    logic [VPI_W-1:0]  vpi_idx;
    logic [VCI_W-1:0]  vci_idx;
    logic [VCI_W-1:0]  vci_mask;
    logic [ADDR_W-1:0] vp_base_sel;
    logic [ADDR_W-1:0] vc_base_sel;

    assign vci_mask = VCI_W'(path_ent.vci_mask);

    chlk_compact #(.W(VPI_W)) u_vp_pack (
        .key        (vpi),
        .mask       (vp_mask),
        .packed_idx (vpi_idx)
    );

    chlk_compact #(.W(VCI_W)) u_vc_pack (
        .key        (vci),
        .mask       (vci_mask),
        .packed_idx (vci_idx)
    );

    always_comb begin
        vp_base_sel = set1 ? vp_base1 : vp_base0;
        vc_base_sel = set1 ? vc_base1 : vc_base0;
        vp_addr     = vp_base_sel + ADDR_W'(vpi_idx);
        vc_addr     = vc_base_sel + ADDR_W'(path_ent.vc_off) + ADDR_W'(vci_idx);
    end
endmodule

// File: rtl/chlk_ctrl.sv
module chlk_ctrl
    import chlk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        hdr_valid,
    output logic        hdr_ready,
    output logic        accept,
    output logic        cap_path,
    output logic        cap_chan,
    output logic        rd_en,
    output logic        sel_chan,
    output logic        done
);
    chlk_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (hdr_valid) state_d = ST_RD_VP;
            ST_RD_VP: state_d = ST_WT_VP;
            ST_WT_VP: state_d = ST_RD_VC;
            ST_RD_VC: state_d = ST_WT_VC;
            ST_WT_VC: state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign hdr_ready = (state_q == ST_IDLE);
    assign accept    = hdr_ready & hdr_valid;
    assign cap_path  = (state_q == ST_WT_VP);
    assign cap_chan  = (state_q == ST_WT_VC);
    assign rd_en     = (state_q == ST_RD_VP) | (state_q == ST_RD_VC);
    assign sel_chan  = (state_q == ST_RD_VC);
    assign done      = (state_q == ST_DONE);
endmodule

// File: rtl/atm_chan_lookup.sv
module atm_chan_lookup
    import chlk_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_multi_phy,
    input  logic [VPI_W-1:0]     cfg_vp_mask,
    input  logic [ADDR_W-1:0]    cfg_vp_base0,
    input  logic [ADDR_W-1:0]    cfg_vc_base0,
    input  logic [ADDR_W-1:0]    cfg_vp_base1,
    input  logic [ADDR_W-1:0]    cfg_vc_base1,
    input  logic                 hdr_valid,
    output logic                 hdr_ready,
    input  logic [PHY_W-1:0]     hdr_phy,
    input  logic [VPI_W-1:0]     hdr_vpi,
    input  logic [VCI_W-1:0]     hdr_vci,
    output logic                 mem_rd,
    output logic [ADDR_W-1:0]    mem_addr,
    input  logic [WORD_W-1:0]    mem_rdata,
    output logic                 res_valid,
    output logic [CODE_W-1:0]    res_code,
    output logic                 res_nomatch,
    output logic [PHY_W-2:0]     res_phy
);
    logic           accept, cap_path, cap_chan, sel_chan;
    chlk_hdr_t      hdr_q;
    logic           set1_q;
    logic [PHY_W-2:0] phy_lo_q;
    chlk_path_ent_t path_q;
    chlk_chan_ent_t chan_w;
    logic [ADDR_W-1:0] vp_addr, vc_addr;

    chlk_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .hdr_valid (hdr_valid),
        .hdr_ready (hdr_ready),
        .accept    (accept),
        .cap_path  (cap_path),
        .cap_chan  (cap_chan),
        .rd_en     (mem_rd),
        .sel_chan  (sel_chan),
        .done      (res_valid)
    );

    chlk_addr #(.ADDR_W(ADDR_W)) u_addr (
        .set1     (set1_q),
        .vp_base0 (cfg_vp_base0),
        .vc_base0 (cfg_vc_base0),
        .vp_base1 (cfg_vp_base1),
        .vc_base1 (cfg_vc_base1),
        .vp_mask  (cfg_vp_mask),
        .vpi      (hdr_q.vpi),
        .vci      (hdr_q.vci),
        .path_ent (path_q),
        .vp_addr  (vp_addr),
        .vc_addr  (vc_addr)
    );

    assign mem_addr = sel_chan ? vc_addr : vp_addr;
    assign chan_w   = chlk_chan_ent_t'(mem_rdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            hdr_q    <= '0;
            set1_q   <= 1'b0;
            phy_lo_q <= '0;
        end else if (accept) begin
            hdr_q    <= '{phy: hdr_phy, vpi: hdr_vpi, vci: hdr_vci};
            set1_q   <= pick_set1(cfg_multi_phy, hdr_phy);
            phy_lo_q <= phy_low(cfg_multi_phy, hdr_phy);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           path_q <= '0;
        else if (cap_path) path_q <= chlk_path_ent_t'(mem_rdata);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_code    <= '0;
            res_nomatch <= 1'b0;
            res_phy     <= '0;
        end else if (cap_chan) begin
            res_code    <= chan_w.code;
            res_nomatch <= chan_w.nomatch;
            res_phy     <= phy_lo_q;
        end
    end
endmodule

// File: rtl/chlk_checker.sv
module chlk_checker (
    input logic        clk,
    input logic        rst,
    input logic        cfg_multi_phy,
    input logic        hdr_valid,
    input logic        hdr_ready,
    input logic        mem_rd,
    input logic        res_valid,
    input logic [15:0] res_code,
    input logic        res_nomatch,
    input logic [3:0]  res_phy
);
    // R1
    reset_exit_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (hdr_ready && !res_valid && !mem_rd));

    // R2
    first_read_follows_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (hdr_valid && hdr_ready) |=> mem_rd);

    // R8
    strobe_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> (!res_valid && hdr_ready));

    // R9
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd || res_valid) |-> !hdr_ready);

    // R11
    result_held_chk: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> ($stable(res_code) && $stable(res_nomatch) && $stable(res_phy)));

    // R7
    single_phy_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !cfg_multi_phy && $stable(cfg_multi_phy)) |-> (res_phy == 4'h0));
endmodule

bind atm_chan_lookup chlk_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .cfg_multi_phy (cfg_multi_phy),
    .hdr_valid     (hdr_valid),
    .hdr_ready     (hdr_ready),
    .mem_rd        (mem_rd),
    .res_valid     (res_valid),
    .res_code      (res_code),
    .res_nomatch   (res_nomatch),
    .res_phy       (res_phy)
);

// File: tb/sim_atm_chan_lookup.sv
`timescale 1ns/1ps
module sim_atm_chan_lookup;

    localparam logic [15:0] VPB0 = 16'h0040;
    localparam logic [15:0] VCB0 = 16'h0100;
    localparam logic [15:0] VPB1 = 16'h0080;
    localparam logic [15:0] VCB1 = 16'h0200;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_multi_phy = 1'b0;
    logic [11:0] cfg_vp_mask = 12'h01F;
    logic        hdr_valid = 1'b0;
    logic        hdr_ready;
    logic [4:0]  hdr_phy = '0;
    logic [11:0] hdr_vpi = '0;
    logic [15:0] hdr_vci = '0;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic [31:0] mem_rdata = '0;
    logic        res_valid;
    logic [15:0] res_code;
    logic        res_nomatch;
    logic [3:0]  res_phy;

    logic [31:0] mem [1024];
    int n_chk = 0;
    int n_bad = 0;
    int wd = 0;

    always #2.5 clk = ~clk;

    atm_chan_lookup u0 (
        .clk(clk), .rst(rst), .cfg_multi_phy(cfg_multi_phy), .cfg_vp_mask(cfg_vp_mask),
        .cfg_vp_base0(VPB0), .cfg_vc_base0(VCB0), .cfg_vp_base1(VPB1), .cfg_vc_base1(VCB1),
        .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_phy(hdr_phy), .hdr_vpi(hdr_vpi),
        .hdr_vci(hdr_vci), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .res_valid(res_valid), .res_code(res_code), .res_nomatch(res_nomatch), .res_phy(res_phy)
    );

    always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[9:0]];

    // {multi, phy, vpi, vci, vp_mask}
    localparam int NV = 8;
    localparam logic [45:0] VEC [NV] = '{
        {1'b0, 5'h00, 12'h013, 16'h0042, 12'h01F},
        {1'b0, 5'h1A, 12'hABC, 16'h1234, 12'h0F0},
        {1'b1, 5'h07, 12'h5A5, 16'hFFFF, 12'h801},
        {1'b1, 5'h13, 12'h3C3, 16'h8001, 12'h00F},
        {1'b1, 5'h1F, 12'hFFF, 16'h0000, 12'h555},
        {1'b0, 5'h10, 12'h000, 16'hBEEF, 12'hFFF},
        {1'b1, 5'h0C, 12'h924, 16'h7E81, 12'h0AA},
        {1'b0, 5'h05, 12'h7FF, 16'h0F0F, 12'h000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] pext16(input logic [15:0] key, input logic [15:0] m);
        logic [15:0] r = '0;
        int p = 0;
        for (int i = 0; i < 16; i++) if (m[i]) begin r[p] = key[i]; p++; end
        return r;
    endfunction

    function automatic logic [15:0] m_vp(input logic mu, input logic [4:0] ph,
                                         input logic [11:0] vpi, input logic [11:0] vm);
        return ((mu && ph[4]) ? VPB1 : VPB0) + pext16({4'h0, vpi}, {4'h0, vm});
    endfunction

    function automatic logic [15:0] m_vc(input logic mu, input logic [4:0] ph, input logic [11:0] vpi,
                                         input logic [15:0] vci, input logic [11:0] vm);
        logic [31:0] e = mem[m_vp(mu, ph, vpi, vm) & 16'h03FF];
        return ((mu && ph[4]) ? VCB1 : VCB0) + e[15:0] + pext16(vci, e[31:16]);
    endfunction

    task automatic lookup(input logic mu, input logic [4:0] ph, input logic [11:0] vpi,
                          input logic [15:0] vci, input logic [11:0] vm, input bit poke);
        logic [15:0] ea = m_vp(mu, ph, vpi, vm);
        logic [15:0] eb = m_vc(mu, ph, vpi, vci, vm);
        logic [31:0] ce = mem[eb & 16'h03FF];
        @(negedge clk);
        cfg_multi_phy = mu; cfg_vp_mask = vm;
        hdr_phy = ph; hdr_vpi = vpi; hdr_vci = vci; hdr_valid = 1'b1;
        chk("R9 ready when idle", 32'(hdr_ready), 32'd1);
        @(negedge clk); hdr_valid = 1'b0;
        chk("R2 first read strobe", 32'(mem_rd), 32'd1);
        chk(mu && ph[4] ? "R6 path address set1" : "R2 path address", 32'(mem_addr), 32'(ea));
        @(negedge clk);
        chk("R9 busy not ready", 32'(hdr_ready), 32'd0);
        if (poke) begin
            hdr_valid = 1'b1; hdr_phy = ~ph; hdr_vpi = ~vpi; hdr_vci = ~vci;
        end
        @(negedge clk);
        hdr_valid = 1'b0;
        chk("R4 second read strobe", 32'(mem_rd), 32'd1);
        chk(poke ? "R9 busy header ignored" : "R4 chan address", 32'(mem_addr), 32'(eb));
        @(negedge clk);
        chk("R8 no early strobe", 32'(res_valid), 32'd0);
        @(negedge clk);
        chk("R8 strobe in fifth cycle", 32'(res_valid), 32'd1);
        chk("R5 code", 32'(res_code), 32'(ce[31:16]));
        chk("R5 nomatch", 32'(res_nomatch), 32'(ce[0]));
        chk(mu ? "R6 phy low bits" : "R7 phy zero", 32'(res_phy), mu ? 32'(ph[3:0]) : 32'd0);
        @(negedge clk);
        chk("R8 strobe one cycle", 32'(res_valid), 32'd0);
        chk("R8 ready again", 32'(hdr_ready), 32'd1);
        chk("R11 code held", 32'(res_code), 32'(ce[31:16]));
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 50000) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual %0d cycles expected completion", wd);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 1024; i++)
            mem[i] = {16'(i * 40503 + 7), 15'(i * 13 + 5), 1'(i % 3 == 0)};
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 ready", 32'(hdr_ready), 32'd1);
        chk("R1 res_valid", 32'(res_valid), 32'd0);
        chk("R1 mem_rd", 32'(mem_rd), 32'd0);
        chk("R1 res_code", 32'(res_code), 32'd0);
        chk("R1 nomatch/phy", {27'd0, res_nomatch, res_phy}, 32'd0);

        for (int v = 0; v < NV; v++)
            lookup(VEC[v][45], VEC[v][44:40], VEC[v][39:28], VEC[v][27:12], VEC[v][11:0], 1'b0);

        // R3 R10: path word with zero VCI mask and offset 0x33
        mem[m_vp(1'b0, 5'h00, 12'h006, 12'h00F) & 16'h03FF] = 32'h0000_0033;
        chk("R10 zero mask address", 32'(m_vc(1'b0, 5'h00, 12'h006, 16'hFFFF, 12'h00F)), 32'(VCB0 + 16'h33));
        lookup(1'b0, 5'h00, 12'h006, 16'hFFFF, 12'h00F, 1'b0);

        // R3: mask field in upper half selects VCI bits 4..10
        mem[m_vp(1'b0, 5'h00, 12'h007, 12'h00F) & 16'h03FF] = 32'h07F0_0010;
        chk("R3 mask field", 32'(m_vc(1'b0, 5'h00, 12'h007, 16'h0550, 12'h00F)), 32'(VCB0 + 16'h10 + 16'h55));
        // R5: reserved bits all ones, hit
        mem[(VCB0 + 16'h10 + 16'h55) & 16'h03FF] = 32'hCAFE_FFFE;
        lookup(1'b0, 5'h00, 12'h007, 16'h0550, 12'h00F, 1'b0);
        chk("R5 reserved ignored code", 32'(res_code), 32'hCAFE);
        chk("R5 reserved ignored hit", 32'(res_nomatch), 32'd0);
        mem[(VCB0 + 16'h10 + 16'h55) & 16'h03FF] = 32'h1357_0001;
        lookup(1'b0, 5'h00, 12'h007, 16'h0550, 12'h00F, 1'b0);
        chk("R5 miss flag", 32'(res_nomatch), 32'd1);

        // R7: single-PHY with PHY bit 4 set uses set 0
        lookup(1'b0, 5'h1F, 12'h021, 16'h00A0, 12'h0FF, 1'b0);
        // R6: same header both sets
        lookup(1'b1, 5'h19, 12'h021, 16'h00A0, 12'h0FF, 1'b0);
        lookup(1'b1, 5'h09, 12'h021, 16'h00A0, 12'h0FF, 1'b0);

        // R9: header offered while busy
        lookup(1'b1, 5'h12, 12'h345, 16'h6789, 12'h3F0, 1'b1);
        lookup(1'b0, 5'h00, 12'h0AA, 16'h5555, 12'h0FF, 1'b0);

        repeat (2) @(negedge clk);
        chk("R11 idle outputs stable", 32'(res_valid), 32'd0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule